// File: doc/BRIEF.md
# Shared-RAM Host Front End with Pass-Through and Register Decode

This block sits between a host processor and an external RAM that the host shares with the internal engine of a serial-bus remote terminal. A host cycle with the register-select input low passes straight through: after one clock the host address, chip select and read/write strobe appear on the RAM port. A host cycle with register-select high goes instead to a small register file. It holds a write-only control byte, a read-only system status word, and a last-command record that keeps the most recent command word and a snapshot of status.

The internal engine asks for the RAM with a request/grant handshake. It gets the RAM only while host chip select is low, and it keeps the RAM until it drops its request. A host cycle that arrives while the engine owns the RAM is flagged as a protocol violation and has no other effect. Every output is registered on one clock, and reset is synchronous and active high.

Top module: `hpt_mem_front`

## Requirements
- R1: When host_cs is high, host_reg_sel is low and the engine is not granted, ram_addr equals host_addr one cycle later.
- R2: In the same transparent cycle, ram_cs is 1 and ram_rd equals host_rd (1 = read) one cycle later.
- R3: A host cycle with host_reg_sel low never changes any internal register. ctrl_bits stays unchanged even for a write at address 0.
- R4: During a transparent host cycle the block does not drive the data bus: host_doe is 0 in the following cycle.
- R5: A register read (host_cs=1, host_reg_sel=1, host_rd=1) with host_addr[1:0]=00 returns status_in on host_dout, with host_doe=1, one cycle later. Register accesses keep ram_cs at 0.
- R6: A register write with host_addr[1:0]=00 loads host_din[7:0] into the control register, and the new value shows on ctrl_bits in the next cycle.
- R7: A pulse on cmd_stb captures cmd_word and the low 8 bits of status_in. A read at host_addr[1:0]=01 returns the captured word, and a read at 10 returns the snapshot zero-extended. Both hold until the next pulse.
- R8: A register write with host_addr[1:0]=01 is a software reset. It clears the control register and both last-command fields.
- R9: host_cs high while eng_gnt is 1 sets viol in the next cycle. The cycle changes no register and does not take over the RAM port.
- R10: eng_gnt rises only after a cycle in which eng_req is high and host_cs is low, and a host cycle wins a same-cycle conflict. The grant stays high while eng_req stays high and falls one cycle after eng_req falls.
- R11: While granted, ram_addr, ram_cs and ram_rd follow eng_addr, eng_cs and eng_rd one cycle later. host_doe is 1 only for an engine read-back cycle (eng_rb=1) with host_cs low, and then host_dout carries eng_rb_data.
- R12: After reset, ctrl_bits=0, eng_gnt=0, ram_cs=0, host_doe=0 and viol=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Host chip select |
| host_reg_sel | input | 1 | High: register access; low: pass-through to RAM |
| host_rd | input | 1 | Host strobe, 1 = read, 0 = write |
| host_addr | input | 11 | Host address |
| host_din | input | 16 | Data bus as seen at the pins |
| host_dout | output | 16 | Data the block places on the bus |
| host_doe | output | 1 | Data bus output enable |
| status_in | input | 16 | Live system status word |
| cmd_stb | input | 1 | Capture pulse for the last-command record |
| cmd_word | input | 16 | Command word to capture |
| eng_req | input | 1 | Engine RAM request |
| eng_cs | input | 1 | Engine RAM select |
| eng_rd | input | 1 | Engine RAM strobe, 1 = read |
| eng_addr | input | 11 | Engine RAM address |
| eng_rb | input | 1 | Engine read-back cycle, block drives data bus |
| eng_rb_data | input | 16 | Data for an engine read-back cycle |
| eng_gnt | output | 1 | Engine owns the RAM port |
| ram_addr | output | 11 | RAM address |
| ram_cs | output | 1 | RAM chip select |
| ram_rd | output | 1 | RAM strobe, 1 = read |
| ctrl_bits | output | 8 | Control register contents |
| viol | output | 1 | Host cycle arrived during engine ownership |

## Verification
The hardest condition to reach is a host cycle that lands while the engine holds the RAM. The stimulus gets the grant first, with the host idle, and holds eng_req high. It then raises host_cs, once as a pass-through and once as a register write, and checks that the violation flag sets, the control byte keeps its value and the RAM port keeps following the engine. A second hard case is the same-cycle conflict: host_cs and eng_req rise together, and the host has to win before the grant follows once the host goes idle.

// File: rtl/hpt_pkg.sv
`timescale 1ns/1ps
package hpt_pkg;
   typedef enum logic [1:0] {OWN_IDLE, OWN_HOST, OWN_ENG} own_e;
   localparam logic [1:0] SEL_SYS  = 2'd0;  // read: status; write: control
   localparam logic [1:0] SEL_LCW  = 2'd1;  // read: last command; write: soft reset
   localparam logic [1:0] SEL_LCS  = 2'd2;  // read: status snapshot
endpackage

// File: rtl/hpt_arbiter.sv
`timescale 1ns/1ps
module hpt_arbiter
   import hpt_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic host_cs,
   input  logic eng_req,
   output logic gnt,
   output own_e owner,
   output logic viol
);
   always_comb begin
      if (gnt)          owner = OWN_ENG;
      else if (host_cs) owner = OWN_HOST;
      else              owner = OWN_IDLE;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         gnt  <= 1'b0;
         viol <= 1'b0;
      end else begin
         gnt  <= gnt ? eng_req : (eng_req & ~host_cs);
         viol <= gnt & host_cs;
      end
   end
endmodule

// File: rtl/hpt_regfile.sv
`timescale 1ns/1ps
module hpt_regfile
   import hpt_pkg::*;
#(
   parameter int DW = 16,
   parameter int CW = 8,
   parameter int SW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          acc_en,
   input  logic          acc_rd,
   input  logic [1:0]    acc_sel,
   input  logic [CW-1:0] wdata,
   input  logic [DW-1:0] status_in,
   input  logic          cmd_stb,
   input  logic [DW-1:0] cmd_word,
   output logic [CW-1:0] ctrl_q,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] lcw_q;
   logic [SW-1:0] lcs_q;
   logic [DW-1:0] lcs_ext;
   logic          wr_ctl, wr_srst;

   assign wr_ctl  = acc_en & ~acc_rd & (acc_sel == SEL_SYS);
   assign wr_srst = acc_en & ~acc_rd & (acc_sel == SEL_LCW);

   generate
      if (SW < DW) begin : g_pad
         assign lcs_ext = {{(DW-SW){1'b0}}, lcs_q};
      end else begin : g_full
         assign lcs_ext = lcs_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || wr_srst) begin
         ctrl_q <= '0;
         lcw_q  <= '0;
         lcs_q  <= '0;
      end else begin
         if (wr_ctl) ctrl_q <= wdata;
         if (cmd_stb) begin
            lcw_q <= cmd_word;
            lcs_q <= status_in[SW-1:0];
         end
      end
   end

   always_comb begin
      case (acc_sel)
         SEL_SYS: rdata = status_in;
         SEL_LCW: rdata = lcw_q;
         SEL_LCS: rdata = lcs_ext;
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/hpt_busdrv.sv
`timescale 1ns/1ps
module hpt_busdrv
   import hpt_pkg::*;
#(
   parameter int AW = 11,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  own_e          owner,
   input  logic          host_cs,
   input  logic          host_reg_sel,
   input  logic          host_rd,
   input  logic [AW-1:0] host_addr,
   input  logic [DW-1:0] reg_rdata,
   input  logic          eng_cs,
   input  logic          eng_rd,
   input  logic [AW-1:0] eng_addr,
   input  logic          eng_rb,
   input  logic [DW-1:0] eng_rb_data,
   output logic [AW-1:0] ram_addr,
   output logic          ram_cs,
   output logic          ram_rd,
   output logic [DW-1:0] dout,
   output logic          doe
);
   always_ff @(posedge clk) begin
      if (rst) begin
         ram_addr <= '0;
         ram_cs   <= 1'b0;
         ram_rd   <= 1'b1;
         dout     <= '0;
         doe      <= 1'b0;
      end else begin
         case (owner)
            OWN_HOST: begin
               ram_cs <= ~host_reg_sel;
               ram_rd <= host_reg_sel | host_rd;
               if (!host_reg_sel) ram_addr <= host_addr;
               doe  <= host_reg_sel & host_rd;
               dout <= (host_reg_sel & host_rd) ? reg_rdata : '0;
            end
            OWN_ENG: begin
               ram_cs   <= eng_cs;
               ram_rd   <= eng_rd;
               ram_addr <= eng_addr;
               doe      <= eng_rb & ~host_cs;
               dout     <= (eng_rb & ~host_cs) ? eng_rb_data : '0;
            end
            default: begin
               ram_cs <= 1'b0;
               ram_rd <= 1'b1;
               doe    <= 1'b0;
               dout   <= '0;
            end
         endcase
      end
   end
endmodule

// File: rtl/hpt_mem_front.sv
`timescale 1ns/1ps
module hpt_mem_front
   import hpt_pkg::*;
#(
   parameter int AW = 11,
   parameter int DW = 16,
   parameter int CW = 8,
   parameter int SW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          host_cs,
   input  logic          host_reg_sel,
   input  logic          host_rd,
   input  logic [AW-1:0] host_addr,
   input  logic [DW-1:0] host_din,
   output logic [DW-1:0] host_dout,
   output logic          host_doe,
   input  logic [DW-1:0] status_in,
   input  logic          cmd_stb,
   input  logic [DW-1:0] cmd_word,
   input  logic          eng_req,
   input  logic          eng_cs,
   input  logic          eng_rd,
   input  logic [AW-1:0] eng_addr,
   input  logic          eng_rb,
   input  logic [DW-1:0] eng_rb_data,
   output logic          eng_gnt,
   output logic [AW-1:0] ram_addr,
   output logic          ram_cs,
   output logic          ram_rd,
   output logic [CW-1:0] ctrl_bits,
   output logic          viol
);
   generate
      if (CW > DW) begin : g_bad_cw
         $error("control width exceeds data width");
      end
      if (SW > DW) begin : g_bad_sw
         $error("snapshot width exceeds data width");
      end
      if (AW < 2) begin : g_bad_aw
         $error("address needs at least two bits for register decode");
      end
   endgenerate

   own_e          owner;
   logic          reg_en;
   logic [DW-1:0] reg_rdata;

   assign reg_en = (owner == OWN_HOST) & host_reg_sel;

   hpt_arbiter u_arb (
      .clk(clk), .rst(rst), .host_cs(host_cs), .eng_req(eng_req),
      .gnt(eng_gnt), .owner(owner), .viol(viol)
   );

   hpt_regfile #(.DW(DW), .CW(CW), .SW(SW)) u_regs (
      .clk(clk), .rst(rst), .acc_en(reg_en), .acc_rd(host_rd),
      .acc_sel(host_addr[1:0]), .wdata(host_din[CW-1:0]),
      .status_in(status_in), .cmd_stb(cmd_stb), .cmd_word(cmd_word),
      .ctrl_q(ctrl_bits), .rdata(reg_rdata)
   );

   hpt_busdrv #(.AW(AW), .DW(DW)) u_bus (
      .clk(clk), .rst(rst), .owner(owner), .host_cs(host_cs),
      .host_reg_sel(host_reg_sel), .host_rd(host_rd), .host_addr(host_addr),
      .reg_rdata(reg_rdata), .eng_cs(eng_cs), .eng_rd(eng_rd),
      .eng_addr(eng_addr), .eng_rb(eng_rb), .eng_rb_data(eng_rb_data),
      .ram_addr(ram_addr), .ram_cs(ram_cs), .ram_rd(ram_rd),
      .dout(host_dout), .doe(host_doe)
   );
endmodule

// File: rtl/hpt_mem_front_chk.sv
`timescale 1ns/1ps
module hpt_mem_front_chk #(
   parameter int AW = 11,
   parameter int DW = 16,
   parameter int CW = 8
) (
   input logic          clk,
   input logic          rst,
   input logic          host_cs,
   input logic          host_reg_sel,
   input logic          host_rd,
   input logic [AW-1:0] host_addr,
   input logic          host_doe,
   input logic          eng_req,
   input logic          eng_gnt,
   input logic [AW-1:0] ram_addr,
   input logic          ram_cs,
   input logic          ram_rd,
   input logic [CW-1:0] ctrl_bits,
   input logic          viol
);
   logic seen;
   always_ff @(posedge clk) seen <= !rst;

   // R1 and R2: transparent host cycle reaches the RAM port
   a_r1_addr_pass: assert property (@(posedge clk) disable iff (rst)
      (seen && $past(host_cs && !host_reg_sel && !eng_gnt)) |->
         (ram_cs && ram_addr == $past(host_addr) && ram_rd == $past(host_rd)));

   // R3: pass-through or violating cycle leaves the control byte alone
   a_r3_ctrl_untouched: assert property (@(posedge clk) disable iff (rst)
      (seen && !$past(host_cs && host_reg_sel && !eng_gnt)) |-> $stable(ctrl_bits));

   // R4: no drive after a transparent host cycle
   a_r4_no_drive: assert property (@(posedge clk) disable iff (rst)
      (seen && $past(host_cs && !host_reg_sel)) |-> !host_doe);

   // R9: host cycle during engine ownership is flagged
   a_r9_viol: assert property (@(posedge clk) disable iff (rst)
      (seen && $past(host_cs && eng_gnt)) |-> (viol && !host_doe));

   // R10: grant held while requested
   a_r10_hold: assert property (@(posedge clk) disable iff (rst)
      (seen && $past(eng_gnt && eng_req)) |-> eng_gnt);

   // R10: grant only rises after a host-idle cycle
   a_r10_grant_idle: assert property (@(posedge clk) disable iff (rst)
      (seen && $rose(eng_gnt)) |-> $past(!host_cs && eng_req));
endmodule

bind hpt_mem_front hpt_mem_front_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
   .clk(clk), .rst(rst), .host_cs(host_cs), .host_reg_sel(host_reg_sel),
   .host_rd(host_rd), .host_addr(host_addr), .host_doe(host_doe),
   .eng_req(eng_req), .eng_gnt(eng_gnt), .ram_addr(ram_addr),
   .ram_cs(ram_cs), .ram_rd(ram_rd), .ctrl_bits(ctrl_bits), .viol(viol)
);

// File: tb/tb_hpt_mem_front.sv
`timescale 1ns/1ps
module tb_hpt_mem_front;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        host_cs = 0, host_reg_sel = 0, host_rd = 0;
   logic [10:0] host_addr = '0;
   logic [15:0] host_din = '0;
   logic [15:0] host_dout;
   logic        host_doe;
   logic [15:0] status_in = '0;
   logic        cmd_stb = 0;
   logic [15:0] cmd_word = '0;
   logic        eng_req = 0, eng_cs = 0, eng_rd = 0, eng_rb = 0;
   logic [10:0] eng_addr = '0;
   logic [15:0] eng_rb_data = '0;
   logic        eng_gnt;
   logic [10:0] ram_addr;
   logic        ram_cs, ram_rd;
   logic [7:0]  ctrl_bits;
   logic        viol;

   always #5 clk = ~clk;

   hpt_mem_front dut (.*);

   typedef struct {
      string       r;
      bit          g_ram; bit cs; bit rd; logic [10:0] a;
      bit          g_oe;  bit oe; logic [15:0] d;
      bit          g_ctl; logic [7:0] c;
      bit          g_arb; bit gnt; bit vl;
      int          due;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   n_run = 0, n_fail = 0;
   bit   done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compare outputs against queued expectations
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].due == cyc) begin
         exp_t it;
         bit   bad;
         it  = q.pop_front();
         bad = 0;
         n_run++;
         if (it.g_ram && (ram_cs !== it.cs || (it.cs && (ram_rd !== it.rd || ram_addr !== it.a)))) begin
            bad = 1;
            $display("FAIL %s: ram cs=%0b rd=%0b addr=%h, expected cs=%0b rd=%0b addr=%h",
                     it.r, ram_cs, ram_rd, ram_addr, it.cs, it.rd, it.a);
         end
         if (it.g_oe && (host_doe !== it.oe || (it.oe && host_dout !== it.d))) begin
            bad = 1;
            $display("FAIL %s: doe=%0b dout=%h, expected doe=%0b dout=%h",
                     it.r, host_doe, host_dout, it.oe, it.d);
         end
         if (it.g_ctl && ctrl_bits !== it.c) begin
            bad = 1;
            $display("FAIL %s: ctrl_bits=%h, expected %h", it.r, ctrl_bits, it.c);
         end
         if (it.g_arb && (eng_gnt !== it.gnt || viol !== it.vl)) begin
            bad = 1;
            $display("FAIL %s: gnt=%0b viol=%0b, expected gnt=%0b viol=%0b",
                     it.r, eng_gnt, viol, it.gnt, it.vl);
         end
         if (bad) n_fail++;
      end
   end

   task automatic host(input bit cs, input bit sel, input bit rd,
                       input logic [10:0] a, input logic [15:0] d);
      host_cs = cs; host_reg_sel = sel; host_rd = rd; host_addr = a; host_din = d;
   endtask

   task automatic eng(input bit req, input bit cs, input bit rd,
                      input logic [10:0] a, input bit rb, input logic [15:0] d);
      eng_req = req; eng_cs = cs; eng_rd = rd; eng_addr = a; eng_rb = rb; eng_rb_data = d;
   endtask

   // driver: push the expectation for the next cycle, then advance
   task automatic expect_step(input string r,
      input bit g_ram, input bit cs, input bit rd, input logic [10:0] a,
      input bit g_oe, input bit oe, input logic [15:0] d,
      input bit g_ctl, input logic [7:0] c,
      input bit g_arb, input bit gnt, input bit vl);
      exp_t e;
      e.r = r; e.g_ram = g_ram; e.cs = cs; e.rd = rd; e.a = a;
      e.g_oe = g_oe; e.oe = oe; e.d = d; e.g_ctl = g_ctl; e.c = c;
      e.g_arb = g_arb; e.gnt = gnt; e.vl = vl; e.due = cyc + 1;
      q.push_back(e);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      expect_step("R12 in reset", 1,0,0,0, 1,0,0, 1,8'h00, 1,0,0);
      rst = 1'b0;
      expect_step("R12 after reset", 1,0,0,0, 1,0,0, 1,8'h00, 1,0,0);
      host(1,0,1,11'h5A3,0);       expect_step("R1 transparent read", 1,1,1,11'h5A3, 1,0,0, 1,8'h00, 1,0,0);
      host(1,0,0,11'h000,16'h00A5); expect_step("R3 pass-through write at addr 0", 1,1,0,11'h000, 1,0,0, 1,8'h00, 1,0,0);
      host(1,0,0,11'h7FF,16'hBEEF); expect_step("R2 R4 transparent write", 1,1,0,11'h7FF, 1,0,0, 1,8'h00, 1,0,0);
      host(1,1,0,11'h000,16'h1234); expect_step("R6 control write", 1,0,0,0, 1,0,0, 1,8'h34, 1,0,0);
      status_in = 16'hC0DE;
      host(1,1,1,11'h000,0);       expect_step("R5 status read", 1,0,0,0, 1,1,16'hC0DE, 1,8'h34, 1,0,0);
      host(0,0,0,0,0); cmd_stb = 1; cmd_word = 16'h2C41; status_in = 16'h00F3;
      expect_step("R7 capture", 1,0,0,0, 1,0,0, 1,8'h34, 1,0,0);
      cmd_stb = 0; status_in = 16'h1111;
      host(1,1,1,11'h001,0);       expect_step("R7 last command word", 1,0,0,0, 1,1,16'h2C41, 0,0, 0,0,0);
      host(1,1,1,11'h002,0);       expect_step("R7 status snapshot", 1,0,0,0, 1,1,16'h00F3, 0,0, 0,0,0);
      host(1,1,0,11'h001,16'hFFFF); expect_step("R8 soft reset ctrl", 0,0,0,0, 1,0,0, 1,8'h00, 0,0,0);
      host(1,1,1,11'h001,0);       expect_step("R8 word cleared", 0,0,0,0, 1,1,16'h0000, 0,0, 0,0,0);
      host(1,1,1,11'h002,0);       expect_step("R8 snapshot cleared", 0,0,0,0, 1,1,16'h0000, 0,0, 0,0,0);
      host(1,1,0,11'h400,16'h00C3); expect_step("R6 write, upper addr ignored", 0,0,0,0, 0,0,0, 1,8'hC3, 0,0,0);
      host(0,0,0,0,0); eng(1,0,0,0,0,0);
      expect_step("R10 grant when host idle", 1,0,0,0, 1,0,0, 0,0, 1,1,0);
      eng(1,1,1,11'h123,0,0);      expect_step("R11 engine read", 1,1,1,11'h123, 1,0,0, 0,0, 1,1,0);
      eng(1,1,0,11'h456,1,16'h55AA); expect_step("R11 engine read-back drive", 1,1,0,11'h456, 1,1,16'h55AA, 0,0, 1,1,0);
      host(1,0,1,11'h001,0);       expect_step("R9 host during grant", 1,1,0,11'h456, 1,0,0, 1,8'hC3, 1,1,1);
      host(1,1,0,11'h000,16'h0011); eng(1,0,1,0,0,0);
      expect_step("R9 register write ignored", 1,0,0,0, 1,0,0, 1,8'hC3, 1,1,1);
      host(0,0,0,0,0); eng(0,0,0,0,0,0);
      expect_step("R10 release", 1,0,0,0, 1,0,0, 1,8'hC3, 1,0,0);
      host(1,0,1,11'h0F0,0); eng(1,0,0,0,0,0);
      expect_step("R10 host wins conflict", 1,1,1,11'h0F0, 1,0,0, 0,0, 1,0,0);
      host(0,0,0,0,0);             expect_step("R10 grant after host idle", 1,0,0,0, 1,0,0, 0,0, 1,1,0);
      expect_step("R10 grant held", 0,0,0,0, 0,0,0, 0,0, 1,1,0);
      eng(0,0,0,0,0,0);            expect_step("R10 grant drops", 0,0,0,0, 0,0,0, 0,0, 1,0,0);
      expect_step("R12 idle again", 1,0,0,0, 1,0,0, 1,8'hC3, 1,0,0);
      @(negedge clk);
      if (q.size() != 0) begin
         n_fail++;
         $display("FAIL queue: %0d expectations left, expected 0", q.size());
      end
      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not end, expected completion");
         summary();
         $finish;
      end
   end
endmodule